// File: doc/BRIEF.md
# Packed-Lane Saturating Adder

This block adds two 64-bit operands lane by lane. Each operand holds a set of packed elements. The element width is chosen at run time from 8, 16, 32 or 64 bits. A run-time lane count sets how many of the low lanes take part in the operation. Lane i occupies the bits starting at i times the element width.

Each lane's sum is formed one bit wider than the element, so no carry is lost. The sum is then clamped to the element's range. A control input picks the range: unsigned, or two's-complement signed. Destination bits that no active lane covers keep the previous destination value, which the caller supplies on an input. A clamp in any active lane can raise a single overflow flag, but only when recording is requested.

The result, the flag and a valid strobe are registered, so they appear one cycle after the request is accepted.

Top module: `pack_sat_add`

## Requirements
- R1: `ew_sel` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i of an operand or of the result sits at bits [i*w + w-1 : i*w].
- R2: With `signed_mode`=0, each lane is treated as unsigned and zero-extended. The lane result is min(a+b, 2^w-1), computed without losing any carry.
- R3: With `signed_mode`=1, each lane is sign-extended from bit w-1. The lane result is the exact sum clamped into the range [-2^(w-1), 2^(w-1)-1].
- R4: Lanes with index at or above `lane_cnt` leave their destination bits equal to `dst_prev`.
- R5: A `lane_cnt` larger than 64/w behaves exactly like 64/w. A `lane_cnt` of 0 returns `dst_prev` unchanged and a clear flag.
- R6: `sat_flag` is 1 exactly when `record_en`=1 and at least one active lane was clamped. Clamping in an inactive lane never sets it.
- R7: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, `result` and `sat_flag` hold their previous values.
- R8: After a synchronous reset, `out_valid`, `result` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the inputs are sampled on this cycle |
| ew_sel | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64) |
| lane_cnt | input | 7 | Number of active lanes |
| signed_mode | input | 1 | 1 selects signed clamping, 0 selects unsigned |
| record_en | input | 1 | 1 enables the overflow flag |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| dst_prev | input | 64 | Prior destination contents, used for inactive lanes |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered packed result |
| sat_flag | output | 1 | Registered recorded-overflow flag |

## Verification
The assertions rely on a small set of input conditions:
- Every control and data input is a known value whenever `in_valid` is high.
- `lane_cnt` may take any 7-bit value, including values past the lane limit.
- The unsigned 64-bit check relies on the sum never being smaller than an operand, which holds for any operand values.

The stimulus drives all inputs on the falling clock edge and raises `in_valid` for a single cycle per request. It sweeps all four widths, lane counts from 0 through two past the lane limit plus 64 and 127, both clamping modes, both record settings, and operand patterns chosen to sit exactly on, just inside and past each lane's range. Idle cycles that change the inputs are interleaved to exercise the hold behaviour.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int DATA_W  = 64;
  localparam int MIN_EW  = 8;
  localparam int NUM_EW  = 4;
  localparam int CNT_W   = $clog2(DATA_W) + 1;
  localparam int EWSEL_W = $clog2(NUM_EW);

  typedef enum logic [EWSEL_W-1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_e;
endpackage

// File: rtl/psa_lane.sv
// One lane: extends both operands by one bit, adds them, and clamps the sum.
module psa_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_mode,
  output logic [W-1:0] y,
  output logic         sat
);
  logic [W:0] ext_a, ext_b, sum;
  logic       ovf;

  always_comb begin
    ext_a = {signed_mode & a[W-1], a};
    ext_b = {signed_mode & b[W-1], b};
    sum   = ext_a + ext_b;
    if (signed_mode) ovf = sum[W] ^ sum[W-1];
    else             ovf = sum[W];
    if (!ovf)             y = sum[W-1:0];
    else if (!signed_mode) y = {W{1'b1}};
    else if (sum[W])      y = {1'b1, {(W-1){1'b0}}};
    else                  y = {1'b0, {(W-1){1'b1}}};
    sat = ovf;
  end
endmodule

// File: rtl/psa_slice.sv
// All the lanes of one element width, with inactive lanes passing dst through.
module psa_slice #(
  parameter int DATA_W = 64,
  parameter int W      = 8,
  parameter int CNT_W  = 7
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] d,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              signed_mode,
  output logic [DATA_W-1:0] y,
  output logic              sat_any
);
  localparam int NL = DATA_W / W;
  logic [NL-1:0] sat_vec;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [W-1:0] ly;
    logic         ls;
    logic         active;
    psa_lane #(.W(W)) u_lane (
      .a(a[i*W +: W]), .b(b[i*W +: W]), .signed_mode(signed_mode),
      .y(ly), .sat(ls)
    );
    assign active         = (cnt > CNT_W'(i));
    assign y[i*W +: W]    = active ? ly : d[i*W +: W];
    assign sat_vec[i]     = active & ls;
  end

  assign sat_any = |sat_vec;
endmodule

// File: rtl/pack_sat_add.sv
module pack_sat_add
  import psa_pkg::*;
#(
  parameter int DW  = psa_pkg::DATA_W,
  parameter int CW  = psa_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    ew_sel,
  input  logic [CW-1:0] lane_cnt,
  input  logic          signed_mode,
  input  logic          record_en,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] dst_prev,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          sat_flag
);
  logic [DW-1:0] y_arr   [NUM_EW];
  logic          sat_arr [NUM_EW];

  for (genvar k = 0; k < NUM_EW; k++) begin : g_width
    psa_slice #(.DATA_W(DW), .W(MIN_EW << k), .CNT_W(CW)) u_slice (
      .a(src_a), .b(src_b), .d(dst_prev), .cnt(lane_cnt),
      .signed_mode(signed_mode), .y(y_arr[k]), .sat_any(sat_arr[k])
    );
  end

  logic [DW-1:0] y_sel;
  logic          sat_sel;

  always_comb begin
    y_sel   = y_arr[0];
    sat_sel = sat_arr[0];
    case (ew_e'(ew_sel))
      EW_16:   begin y_sel = y_arr[1]; sat_sel = sat_arr[1]; end
      EW_32:   begin y_sel = y_arr[2]; sat_sel = sat_arr[2]; end
      EW_64:   begin y_sel = y_arr[3]; sat_sel = sat_arr[3]; end
      default: begin y_sel = y_arr[0]; sat_sel = sat_arr[0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= y_sel;
        sat_flag <= record_en & sat_sel;
      end
    end
  end
endmodule

// File: rtl/psa_chk.sv
module psa_chk #(
  parameter int DW = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    ew_sel,
  input logic [CW-1:0] lane_cnt,
  input logic          signed_mode,
  input logic          record_en,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] dst_prev,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          sat_flag
);
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !sat_flag));

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(sat_flag)));

  a_r6_no_record: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !record_en) |=> !sat_flag);

  a_r5_zero_lanes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_cnt == '0) |=> (result == $past(dst_prev) && !sat_flag));

  a_r2_unsigned_floor: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ew_sel == 2'd3 && !signed_mode && lane_cnt != '0)
      |=> (result >= $past(src_a)));
endmodule

bind pack_sat_add psa_chk #(.DW(DW), .CW(CW)) u_psa_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ew_sel(ew_sel),
  .lane_cnt(lane_cnt), .signed_mode(signed_mode), .record_en(record_en),
  .src_a(src_a), .dst_prev(dst_prev), .out_valid(out_valid),
  .result(result), .sat_flag(sat_flag)
);

// File: tb/tb_pack_sat_add.sv
module tb_pack_sat_add;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  ew_sel = '0;
  logic [6:0]  lane_cnt = '0;
  logic        signed_mode = 1'b0;
  logic        record_en = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, dst_prev = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        sat_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;

  always #4 clk = ~clk;

  pack_sat_add dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ew_sel(ew_sel),
    .lane_cnt(lane_cnt), .signed_mode(signed_mode), .record_en(record_en),
    .src_a(src_a), .src_b(src_b), .dst_prev(dst_prev),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  function automatic logic [63:0] rnd();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  // Reference model written from R1..R6
  task automatic model(input int ew, input int cnt, input bit sgn, input bit rec,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                       output logic [63:0] r, output bit f);
    int w  = 8 << ew;
    int nl = 64 / w;
    bit any = 0;
    r = d;
    for (int i = 0; i < nl; i++) begin
      if (i < cnt) begin
        logic signed [65:0] xa, xb, s, mx, mn;
        xa = 66'(a >> (i * w));
        xb = 66'(b >> (i * w));
        xa = xa & ((66'sd1 <<< w) - 66'sd1);
        xb = xb & ((66'sd1 <<< w) - 66'sd1);
        if (sgn && xa[w-1]) xa = xa - (66'sd1 <<< w);
        if (sgn && xb[w-1]) xb = xb - (66'sd1 <<< w);
        s = xa + xb;
        if (sgn) begin
          mx = (66'sd1 <<< (w - 1)) - 66'sd1;
          mn = -(66'sd1 <<< (w - 1));
        end else begin
          mx = (66'sd1 <<< w) - 66'sd1;
          mn = 66'sd0;
        end
        if (s > mx) begin s = mx; any = 1; end
        else if (s < mn) begin s = mn; any = 1; end
        for (int k = 0; k < w; k++) r[i*w + k] = s[k];
      end
    end
    f = rec & any;
  endtask

  task automatic check64(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int ew, input int cnt, input bit sgn, input bit rec,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    logic [63:0] er;
    bit ef;
    string tag;
    model(ew, cnt, sgn, rec, a, b, d, er, ef);
    @(negedge clk);
    in_valid = 1'b1; ew_sel = 2'(ew); lane_cnt = 7'(cnt);
    signed_mode = sgn; record_en = rec; src_a = a; src_b = b; dst_prev = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (cnt == 0)              tag = "R5 zero lanes";
    else if (cnt > 64 / (8 << ew)) tag = "R5 clipped count";
    else if (cnt < 64 / (8 << ew)) tag = "R4 partial lanes";
    else if (sgn)              tag = "R3 signed R1 layout";
    else                       tag = "R2 unsigned R1 layout";
    check64(result === er, tag, result, er);
    check64(sat_flag === ef, "R6 sat flag", 64'(sat_flag), 64'(ef));
    check64(out_valid === 1'b1, "R7 valid after request", 64'(out_valid), 64'd1);
  endtask

  task automatic idle_check();
    logic [63:0] prev_r;
    logic        prev_f;
    prev_r = result;
    prev_f = sat_flag;
    @(negedge clk);
    src_a = rnd(); src_b = rnd(); dst_prev = rnd(); record_en = 1'b1;
    lane_cnt = 7'd64; ew_sel = 2'd0;
    @(negedge clk);
    check64(result === prev_r, "R7 hold result", result, prev_r);
    check64(sat_flag === prev_f, "R7 hold flag", 64'(sat_flag), 64'(prev_f));
    check64(out_valid === 1'b0, "R7 valid idle", 64'(out_valid), 64'd0);
  endtask

  initial begin
    logic [63:0] pa, pb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check64(out_valid === 1'b0, "R8 reset valid", 64'(out_valid), 64'd0);
    check64(result === 64'd0, "R8 reset result", result, 64'd0);
    check64(sat_flag === 1'b0, "R8 reset flag", 64'(sat_flag), 64'd0);

    for (int ew = 0; ew < 4; ew++) begin
      for (int ci = 0; ci < 13; ci++) begin
        int nl = 64 / (8 << ew);
        int cnt = (ci <= nl + 2) ? ci : ((ci % 2) ? 64 : 127);
        for (int sgn = 0; sgn < 2; sgn++) begin
          for (int rec = 0; rec < 2; rec++) begin
            for (int p = 0; p < 7; p++) begin
              case (p)
                0: begin pa = '1; pb = '1; end
                1: begin pa = 64'h7F7F_7F7F_7F7F_7F7F; pb = 64'h0101_0101_0101_0101; end
                2: begin pa = 64'h8080_8080_8080_8080; pb = 64'h8080_8080_8080_8080; end
                3: begin pa = 64'h7FFF_FFFF_7FFF_7F7E; pb = 64'h0000_0000_0000_0001; end
                4: begin pa = 64'h8000_0000_8000_8081; pb = 64'hFFFF_FFFF_FFFF_FFFF; end
                default: begin pa = rnd(); pb = rnd(); end
              endcase
              run_op(ew, cnt, sgn[0], rec[0], pa, pb, rnd());
            end
          end
        end
        idle_check();
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule